// File: doc/BRIEF.md
# ATA PIO Task-File Register Block

This block is the device side of a legacy ATA register window. A host writes the geometry registers through a small byte-wide port window: drive/head, sector count, sector number, and the two cylinder bytes. It then writes a command code. For a sector read, the block turns the cylinder/head/sector triple into a linear byte address. It asks an external byte-stream storage interface for the data and holds the returned bytes in a local buffer. When the whole block has arrived, it raises an interrupt, and the host then drains the buffer one byte per read of the data port.

Status reads always show drive-ready and seek-complete. The data-request bit is added while unread bytes remain. The block pulses the interrupt line each time the host reads a byte that sits at the start of a sector. It also answers an identify command with a short geometry block, and it acknowledges two housekeeping commands with a bare interrupt. The sector size, buffer depth, identify length, drive geometry and address widths are all parameters.

Top module: `ata_taskfile`

## Requirements
- R1: After synchronous reset: the status read is 0x50, the drive/head read-back (offset 6) is 0xFF, the data port (offset 0) reads 0x00, and neither `req_valid` nor `irq` is high.
- R2: A read at offset 7 returns 0x50, with bit 3 also set while unread bytes remain in the buffer. A read at window offset 0x206 returns the same value.
- R3: A write to offset 6 with bit 4 set is ignored. Any other write there stores the whole byte for read-back at offset 6, and its low four bits become the head number.
- R4: Writes to offset 4 change only the low byte of the 16-bit cylinder value, and writes to offset 5 change only its high byte.
- R5: Command 0x20 requests storage at byte address ((cylinder × HEADS + head) × SECTORS_PER_TRACK + sector − 1) × SECTOR_BYTES.
- R6: A sector count of N requests N × SECTOR_BYTES bytes, and a count of 0 requests 256 sectors. The request length is capped at the buffer size of BUF_SECTORS × SECTOR_BYTES.
- R7: `req_valid` stays high, with `req_addr` and `req_len` stable, until `req_ready` is seen. The status shows no data request before the last byte has been filled. A single one-cycle `irq` pulse follows the last accepted `fill_valid` byte.
- R8: Each data-port read returns the next buffered byte in storage order and advances the read position. If that position is a multiple of SECTOR_BYTES, `irq` pulses in the following cycle. Reads past the end return 0x00 and raise no interrupt.
- R9: Reads at offsets 1, 2 and 3 return 0xFF. Reads at offsets 4 and 5 return 0x00.
- R10: Commands 0x91 and 0x10 each produce one `irq` pulse. They start no storage request and leave the buffered data and read position untouched.
- R11: Command 0xEC restarts the read position and exposes ID_BYTES bytes at the data port. Byte 0 is 0x40, bytes 2 and 3 hold CYLINDERS (low byte first), bytes 6 and 7 hold HEADS, byte 12 holds SECTORS_PER_TRACK, and every other byte is 0. The command also pulses `irq`.
- R12: A command written while a storage fetch is outstanding has no effect. Any command code other than 0x20, 0xEC, 0x91 and 0x10 also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | HOST_AW | Offset of the access within the port window |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the current `bus_addr` (combinational) |
| irq | output | 1 | One-cycle interrupt request pulse |
| req_valid | output | 1 | Storage fetch request pending |
| req_ready | input | 1 | Storage accepts the request |
| req_addr | output | STORE_AW | Starting byte address of the fetch |
| req_len | output | PTR_W | Number of bytes to fetch |
| fill_valid | input | 1 | A fetched byte is presented |
| fill_data | input | 8 | Fetched byte |

## Verification
The bench builds the block with an 8-byte sector, a four-sector (32-byte) buffer and a 16-byte identify block, and keeps the 16-head, 63-sector geometry. With these small sizes, every buffered byte of every transfer can be read back and compared. Sector-boundary interrupts come every eight reads, so both boundary and non-boundary reads are covered many times. Counts 5 and 0 (256 sectors) both run into the length cap. The sweep walks the sector count through 1 to 5 and 0 with a different cylinder, head and sector for each run, which exercises the address arithmetic across several geometry values.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_FILL = 2'd2
   } fetch_state_t;

   localparam logic [7:0] CMD_READ   = 8'h20;
   localparam logic [7:0] CMD_IDENT  = 8'hEC;
   localparam logic [7:0] CMD_SETPAR = 8'h91;
   localparam logic [7:0] CMD_RECAL  = 8'h10;

   localparam logic [7:0] STATUS_BASE = 8'h50;
   localparam logic [7:0] STATUS_DRQ  = 8'h08;
   localparam int         ALT_STATUS_OFF = 'h206;

   localparam logic [2:0] OFF_DATA   = 3'd0;
   localparam logic [2:0] OFF_COUNT  = 3'd2;
   localparam logic [2:0] OFF_SECTOR = 3'd3;
   localparam logic [2:0] OFF_CYL_LO = 3'd4;
   localparam logic [2:0] OFF_CYL_HI = 3'd5;
   localparam logic [2:0] OFF_DRIVE  = 3'd6;
   localparam logic [2:0] OFF_CMD    = 3'd7;

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic [2:0] wr_off,
   input  logic [7:0] wr_data,
   output logic [7:0] drive_q,
   output logic [3:0] head_q,
   output logic [7:0] count_q,
   output logic [7:0] sector_q,
   output logic [15:0] cyl_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         drive_q  <= 8'hFF;
         head_q   <= 4'd0;
         count_q  <= 8'd0;
         sector_q <= 8'd0;
         cyl_q    <= 16'd0;
      end else if (wr_en) begin
         case (wr_off)
            OFF_COUNT:  count_q <= wr_data;
            OFF_SECTOR: sector_q <= wr_data;
            OFF_CYL_LO: cyl_q[7:0] <= wr_data;
            OFF_CYL_HI: cyl_q[15:8] <= wr_data;
            OFF_DRIVE: begin
               // selecting the second device leaves this one untouched
               if (!wr_data[4]) begin
                  drive_q <= wr_data;
                  head_q  <= wr_data[3:0];
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ata_tf_addr.sv
module ata_tf_addr #(
   parameter int SECTOR_BYTES = 512,
   parameter int BUF_BYTES    = 1024,
   parameter int HEADS        = 16,
   parameter int SPT          = 63,
   parameter int STORE_AW     = 40,
   parameter int PTR_W        = 11
) (
   input  logic [15:0]         cyl,
   input  logic [3:0]          head,
   input  logic [7:0]          sector,
   input  logic [7:0]          count,
   output logic [STORE_AW-1:0] byte_addr,
   output logic [PTR_W-1:0]    xfer_len
);

   localparam int SB_LG     = $clog2(SECTOR_BYTES);
   localparam int FULL_MAX  = 256 * SECTOR_BYTES;
   localparam int FULL_W    = $clog2(FULL_MAX + 1);
   localparam int HEADS_LG  = $clog2(HEADS);

   logic [STORE_AW-1:0] track;
   logic [STORE_AW-1:0] linear;
   logic [8:0]          n_sectors;
   logic [FULL_W-1:0]   full_len;

   generate
      if ((1 << HEADS_LG) == HEADS) begin : g_heads_shift
         assign track = (STORE_AW'(cyl) << HEADS_LG) + STORE_AW'(head);
      end else begin : g_heads_mul
         assign track = STORE_AW'(cyl) * STORE_AW'(HEADS) + STORE_AW'(head);
      end
   endgenerate

   assign linear    = track * STORE_AW'(SPT) + STORE_AW'(sector) - STORE_AW'(1);
   assign byte_addr = linear << SB_LG;

   assign n_sectors = (count == 8'd0) ? 9'd256 : {1'b0, count};
   assign full_len  = FULL_W'(n_sectors) << SB_LG;

   generate
      if (FULL_MAX <= BUF_BYTES) begin : g_no_cap
         assign xfer_len = PTR_W'(full_len);
      end else begin : g_cap
         assign xfer_len = (full_len > FULL_W'(BUF_BYTES)) ? PTR_W'(BUF_BYTES)
                                                           : PTR_W'(full_len);
      end
   endgenerate

endmodule

// File: rtl/ata_tf_buffer.sv
module ata_tf_buffer #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
   parameter int CYLINDERS = 1024,
   parameter int HEADS     = 16,
   parameter int SPT       = 63,
   parameter int PTR_W     = 11
) (
   input  logic [PTR_W-1:0] idx,
   output logic [7:0]       id_byte
);

   always_comb begin
      id_byte = 8'h00;
      if (idx == PTR_W'(0))       id_byte = 8'h40;
      else if (idx == PTR_W'(2))  id_byte = 8'(CYLINDERS);
      else if (idx == PTR_W'(3))  id_byte = 8'(CYLINDERS >> 8);
      else if (idx == PTR_W'(6))  id_byte = 8'(HEADS);
      else if (idx == PTR_W'(7))  id_byte = 8'(HEADS >> 8);
      else if (idx == PTR_W'(12)) id_byte = 8'(SPT);
   end

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
   import ata_tf_pkg::*;
#(
   parameter int SECTOR_BYTES  = 512,
   parameter int BUF_SECTORS   = 2,
   parameter int ID_BYTES      = 512,
   parameter int CYLINDERS     = 1024,
   parameter int HEADS         = 16,
   parameter int SPT           = 63,
   parameter int STORE_AW      = 40,
   parameter int HOST_AW       = 10,
   parameter bit ALT_STATUS_EN = 1'b1,
   localparam int BUF_BYTES    = SECTOR_BYTES * BUF_SECTORS,
   localparam int MAX_BYTES    = (BUF_BYTES > ID_BYTES) ? BUF_BYTES : ID_BYTES,
   localparam int PTR_W        = $clog2(MAX_BYTES + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [HOST_AW-1:0]  bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   output logic                irq,
   output logic                req_valid,
   input  logic                req_ready,
   output logic [STORE_AW-1:0] req_addr,
   output logic [PTR_W-1:0]    req_len,
   input  logic                fill_valid,
   input  logic [7:0]          fill_data
);

   localparam int SB_LG  = $clog2(SECTOR_BYTES);
   localparam int BUF_AW = $clog2(BUF_BYTES);
   localparam int ID_AW  = $clog2(ID_BYTES);

   // elaboration-time parameter checks
   generate
      if (SECTOR_BYTES < 2 || (1 << SB_LG) != SECTOR_BYTES) begin : g_bad_sb
         $error("SECTOR_BYTES must be a power of two of at least 2");
      end
      if (BUF_SECTORS < 1) begin : g_bad_buf
         $error("BUF_SECTORS must be at least 1");
      end
      if (ID_BYTES < 14) begin : g_bad_id
         $error("ID_BYTES must cover the geometry words");
      end
      if (HOST_AW < 10) begin : g_bad_haw
         $error("HOST_AW must reach the alternate status offset");
      end
      if (STORE_AW < 32) begin : g_bad_saw
         $error("STORE_AW too narrow for the CHS address range");
      end
   endgenerate

   // ---------------- decode ----------------
   logic [2:0] off;
   logic       in_win;
   logic       alt_hit;
   logic       cmd_wr;
   logic       data_rd;

   assign off     = bus_addr[2:0];
   assign in_win  = (bus_addr[HOST_AW-1:3] == '0);
   assign cmd_wr  = bus_wr && in_win && (off == OFF_CMD);
   assign data_rd = bus_rd && in_win && (off == OFF_DATA);

   generate
      if (ALT_STATUS_EN) begin : g_alt
         assign alt_hit = (bus_addr == HOST_AW'(ALT_STATUS_OFF));
      end else begin : g_no_alt
         assign alt_hit = 1'b0;
      end
   endgenerate

   // ---------------- task-file registers ----------------
   logic [7:0]  drive_q;
   logic [3:0]  head_q;
   logic [7:0]  count_q;
   logic [7:0]  sector_q;
   logic [15:0] cyl_q;

   ata_tf_regs u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_wr && in_win),
      .wr_off   (off),
      .wr_data  (bus_wdata),
      .drive_q  (drive_q),
      .head_q   (head_q),
      .count_q  (count_q),
      .sector_q (sector_q),
      .cyl_q    (cyl_q)
   );

   // ---------------- address arithmetic ----------------
   logic [STORE_AW-1:0] calc_addr;
   logic [PTR_W-1:0]    calc_len;

   ata_tf_addr #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .BUF_BYTES    (BUF_BYTES),
      .HEADS        (HEADS),
      .SPT          (SPT),
      .STORE_AW     (STORE_AW),
      .PTR_W        (PTR_W)
   ) u_addr (
      .cyl       (cyl_q),
      .head      (head_q),
      .sector    (sector_q),
      .count     (count_q),
      .byte_addr (calc_addr),
      .xfer_len  (calc_len)
   );

   // ---------------- fetch control and read position ----------------
   fetch_state_t        fstate;
   logic [PTR_W-1:0]    ptr;
   logic [PTR_W-1:0]    len;
   logic [PTR_W-1:0]    fill_idx;
   logic                id_mode;
   logic [STORE_AW-1:0] req_addr_q;
   logic [PTR_W-1:0]    req_len_q;
   logic                irq_q;
   logic                drq;

   assign drq = (ptr < len);

   always_ff @(posedge clk) begin
      if (rst) begin
         fstate     <= ST_IDLE;
         ptr        <= '0;
         len        <= '0;
         fill_idx   <= '0;
         id_mode    <= 1'b0;
         req_addr_q <= '0;
         req_len_q  <= '0;
         irq_q      <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (fstate)
            ST_IDLE: begin
               if (cmd_wr) begin
                  case (bus_wdata)
                     CMD_READ: begin
                        req_addr_q <= calc_addr;
                        req_len_q  <= calc_len;
                        ptr        <= '0;
                        len        <= '0;
                        id_mode    <= 1'b0;
                        fstate     <= ST_REQ;
                     end
                     CMD_IDENT: begin
                        ptr     <= '0;
                        len     <= PTR_W'(ID_BYTES);
                        id_mode <= 1'b1;
                        irq_q   <= 1'b1;
                     end
                     CMD_SETPAR, CMD_RECAL: irq_q <= 1'b1;
                     default: ;
                  endcase
               end else if (data_rd && drq) begin
                  ptr <= ptr + 1'b1;
                  if (ptr[SB_LG-1:0] == '0) irq_q <= 1'b1;
               end
            end
            ST_REQ: begin
               if (req_ready) begin
                  fill_idx <= '0;
                  fstate   <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (fill_valid) begin
                  fill_idx <= fill_idx + 1'b1;
                  if (fill_idx == req_len_q - 1'b1) begin
                     len    <= req_len_q;
                     irq_q  <= 1'b1;
                     fstate <= ST_IDLE;
                  end
               end
            end
            default: fstate <= ST_IDLE;
         endcase
      end
   end

   assign irq       = irq_q;
   assign req_valid = (fstate == ST_REQ);
   assign req_addr  = req_addr_q;
   assign req_len   = req_len_q;

   // ---------------- data path ----------------
   logic [7:0] buf_byte;
   logic [7:0] id_byte;
   logic [7:0] data_byte;

   ata_tf_buffer #(
      .DEPTH (BUF_BYTES),
      .AW    (BUF_AW)
   ) u_buf (
      .clk   (clk),
      .we    ((fstate == ST_FILL) && fill_valid),
      .waddr (fill_idx[BUF_AW-1:0]),
      .wdata (fill_data),
      .raddr (ptr[BUF_AW-1:0]),
      .rdata (buf_byte)
   );

   ata_tf_ident #(
      .CYLINDERS (CYLINDERS),
      .HEADS     (HEADS),
      .SPT       (SPT),
      .PTR_W     (PTR_W)
   ) u_ident (
      .idx     (ptr),
      .id_byte (id_byte)
   );

   assign data_byte = !drq ? 8'h00 : (id_mode ? id_byte : buf_byte);

   logic [7:0] status;
   assign status = STATUS_BASE | (drq ? STATUS_DRQ : 8'h00);

   always_comb begin
      bus_rdata = 8'h00;
      if (alt_hit) begin
         bus_rdata = status;
      end else if (in_win) begin
         case (off)
            OFF_DATA:                       bus_rdata = data_byte;
            3'd1, OFF_COUNT, OFF_SECTOR:    bus_rdata = 8'hFF;
            OFF_DRIVE:                      bus_rdata = drive_q;
            OFF_CMD:                        bus_rdata = status;
            default:                        bus_rdata = 8'h00;
         endcase
      end
   end

   // ID_AW kept for sizing checks of the identify window
   generate
      if (ID_AW > PTR_W) begin : g_bad_ptr
         $error("read position too narrow for the identify block");
      end
   endgenerate

endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker #(
   parameter int SECTOR_BYTES = 512,
   parameter int BUF_BYTES    = 1024,
   parameter int STORE_AW     = 40,
   parameter int HOST_AW      = 10,
   parameter int PTR_W        = 11
) (
   input logic                clk,
   input logic                rst,
   input logic [HOST_AW-1:0]  bus_addr,
   input logic                bus_rd,
   input logic [7:0]          bus_rdata,
   input logic                irq,
   input logic                req_valid,
   input logic                req_ready,
   input logic [STORE_AW-1:0] req_addr,
   input logic [PTR_W-1:0]    req_len
);

   logic status_hit;
   logic ff_hit;
   assign status_hit = (bus_addr == HOST_AW'(7)) || (bus_addr == HOST_AW'('h206));
   assign ff_hit     = (bus_addr == HOST_AW'(1)) || (bus_addr == HOST_AW'(2)) ||
                       (bus_addr == HOST_AW'(3));

   // R1: first cycle after reset is quiet
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!irq && !req_valid));

   // R2: fixed status bits on both status locations
   assert_status_bits_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && status_hit) |-> (bus_rdata[7:4] == 4'h5 && bus_rdata[2:0] == 3'b000));

   // R6: request length is whole sectors within the buffer
   assert_req_len_R6: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> (req_len != '0 && int'(req_len) <= BUF_BYTES &&
                     (int'(req_len) % SECTOR_BYTES) == 0));

   // R7: request held stable until accepted
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

   // R9: unused task-file reads return all ones
   assert_ff_reads_R9: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && ff_hit) |-> (bus_rdata == 8'hFF));

   // R12: no interrupt while a fetch request is pending
   assert_quiet_busy_R12: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> !irq);

endmodule

bind ata_taskfile ata_tf_checker #(
   .SECTOR_BYTES (SECTOR_BYTES),
   .BUF_BYTES    (BUF_BYTES),
   .STORE_AW     (STORE_AW),
   .HOST_AW      (HOST_AW),
   .PTR_W        (PTR_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_len   (req_len)
);

// File: tb/tb_ata_taskfile.sv
module tb_ata_taskfile;

   localparam int SB   = 8;
   localparam int BUFS = 4;
   localparam int IDB  = 16;
   localparam int HD   = 16;
   localparam int SP   = 63;
   localparam int CY   = 20;
   localparam int SAW  = 40;
   localparam int HAW  = 10;
   localparam int BUFB = SB * BUFS;
   localparam int PW   = $clog2(((BUFB > IDB) ? BUFB : IDB) + 1);

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [HAW-1:0] bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic           bus_rd = 1'b0;
   logic [7:0]     bus_wdata = '0;
   logic [7:0]     bus_rdata;
   logic           irq;
   logic           req_valid;
   logic           req_ready = 1'b0;
   logic [SAW-1:0] req_addr;
   logic [PW-1:0]  req_len;
   logic           fill_valid = 1'b0;
   logic [7:0]     fill_data = '0;

   always #2 clk = ~clk;

   ata_taskfile #(
      .SECTOR_BYTES (SB),
      .BUF_SECTORS  (BUFS),
      .ID_BYTES     (IDB),
      .CYLINDERS    (CY),
      .HEADS        (HD),
      .SPT          (SP),
      .STORE_AW     (SAW),
      .HOST_AW      (HAW),
      .ALT_STATUS_EN(1'b1)
   ) dut (
      .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata, .irq,
      .req_valid, .req_ready, .req_addr, .req_len, .fill_valid, .fill_data
   );

   int errors = 0;
   int checks = 0;
   int reqs   = 0;
   logic [SAW-1:0] last_addr = '0;
   int last_len = 0;

   function automatic logic [7:0] pat(logic [SAW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d, output bit irq_o);
      @(negedge clk);
      bus_addr = HAW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      irq_o = irq;
   endtask

   task automatic rd(int a, output logic [7:0] d, output bit irq_o);
      @(negedge clk);
      bus_addr = HAW'(a); bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      irq_o = irq;
   endtask

   // storage model: accepts after a delay, streams bytes with gaps
   initial begin
      forever begin
         @(negedge clk);
         if (req_valid) begin
            repeat (2) @(negedge clk);
            req_ready = 1'b1;
            last_addr = req_addr;
            last_len  = int'(req_len);
            reqs++;
            @(negedge clk);
            req_ready = 1'b0;
            for (int i = 0; i < last_len; i++) begin
               if (i % 3 == 2) begin
                  fill_valid = 1'b0;
                  @(negedge clk);
               end
               fill_valid = 1'b1;
               fill_data  = pat(last_addr + SAW'(i));
               @(negedge clk);
            end
            fill_valid = 1'b0;
         end
      end
   end

   task automatic do_xfer(int cyl, int head, int sec, int cnt, bit wr_drive);
      bit          ir;
      logic [7:0]  d;
      bit          got;
      longint      exp_addr;
      int          nsec;
      int          exp_len;
      int          reqs0;
      nsec     = (cnt == 0) ? 256 : cnt;
      exp_len  = (nsec * SB > BUFB) ? BUFB : nsec * SB;
      exp_addr = (((longint'(cyl) * HD + head) * SP) + sec - 1) * SB;
      if (wr_drive) wr(6, 8'hA0 | 8'(head), ir);
      wr(2, 8'(cnt), ir);
      wr(3, 8'(sec), ir);
      wr(4, 8'(cyl), ir);
      wr(5, 8'(cyl >> 8), ir);
      reqs0 = reqs;
      wr(7, 8'h20, ir);
      rd(7, d, ir);
      chk(d == 8'h50, "R7 no DRQ before fill complete", d, 8'h50);
      wr(7, 8'h91, ir);
      chk(!ir, "R12 command ignored while busy", ir, 0);
      got = 1'b0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (irq) begin got = 1'b1; break; end
      end
      chk(got, "R7 irq after fill", got, 1);
      @(negedge clk);
      chk(!irq, "R7 irq one cycle", irq, 0);
      chk(reqs == reqs0 + 1, "R12 single request", reqs - reqs0, 1);
      chk(last_addr == SAW'(exp_addr), "R5 request address", last_addr, exp_addr);
      chk(last_len == exp_len, "R6 request length", last_len, exp_len);
      rd(7, d, ir);
      chk(d == 8'h58, "R2 status with DRQ", d, 8'h58);
      rd('h206, d, ir);
      chk(d == 8'h58, "R2 alternate status", d, 8'h58);
      for (int i = 0; i < exp_len; i++) begin
         logic [7:0] e;
         e = pat(SAW'(exp_addr) + SAW'(i));
         rd(0, d, ir);
         chk(d == e, "R8 data byte", d, e);
         chk(ir == (i % SB == 0), "R8 sector irq", ir, (i % SB == 0));
         if (i == 4) begin
            wr(7, 8'h91, ir);
            chk(ir, "R10 cmd 91 irq", ir, 1);
            wr(7, 8'h10, ir);
            chk(ir, "R10 cmd 10 irq", ir, 1);
            wr(7, 8'h55, ir);
            chk(!ir, "R12 unknown cmd no irq", ir, 0);
            rd(7, d, ir);
            chk(d == 8'h58, "R10 DRQ kept", d, 8'h58);
         end
      end
      rd(0, d, ir);
      chk(d == 8'h00 && !ir, "R8 read past end", d, 0);
      rd(7, d, ir);
      chk(d == 8'h50, "R2 status drained", d, 8'h50);
      chk(reqs == reqs0 + 1, "R10 no extra request", reqs - reqs0, 1);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit         ir;
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1
      chk(!irq && !req_valid, "R1 outputs idle", {irq, req_valid}, 0);
      rd(7, d, ir); chk(d == 8'h50, "R1 status", d, 8'h50);
      rd(6, d, ir); chk(d == 8'hFF, "R1 drive readback", d, 8'hFF);
      rd(0, d, ir); chk(d == 8'h00 && !ir, "R1 data empty", d, 0);
      // R9
      for (int a = 1; a <= 3; a++) begin
         rd(a, d, ir); chk(d == 8'hFF, "R9 offset reads FF", d, 8'hFF);
      end
      rd(4, d, ir); chk(d == 8'h00, "R9 offset 4 zero", d, 0);
      rd(5, d, ir); chk(d == 8'h00, "R9 offset 5 zero", d, 0);
      // R3
      wr(6, 8'hA3, ir);
      wr(6, 8'hB5, ir);
      rd(6, d, ir); chk(d == 8'hA3, "R3 slave write ignored", d, 8'hA3);
      wr(6, 8'hE7, ir);
      rd(6, d, ir); chk(d == 8'hE7, "R3 drive latched", d, 8'hE7);
      wr(6, 8'hA3, ir);
      // R4: low byte then high byte alone
      wr(4, 8'h12, ir);
      wr(5, 8'h00, ir);
      wr(2, 8'd1, ir);
      wr(3, 8'd1, ir);
      wr(5, 8'h01, ir);
      begin
         longint ea;
         int r0;
         bit got;
         ea = (((longint'(16'h0112) * HD + 3) * SP) + 0) * SB;
         r0 = reqs;
         wr(7, 8'h20, ir);
         got = 1'b0;
         for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (irq) begin got = 1'b1; break; end
         end
         chk(got && reqs == r0 + 1, "R4 fetch done", reqs - r0, 1);
         chk(last_addr == SAW'(ea), "R4 cylinder bytes", last_addr, ea);
         for (int i = 0; i < SB; i++) rd(0, d, ir);
      end
      // R5 R6 R7 R8 R10 R12 sweep
      do_xfer(5, 3, 1, 1, 1'b0);
      for (int i = 0; i < 6; i++) begin
         int c;
         c = (i == 5) ? 0 : i + 1;
         do_xfer(3 * i + 1, (i * 5) % 16, i * 10 + 1, c, 1'b1);
      end
      do_xfer(513, 15, 63, 2, 1'b1);
      // R11 identify
      wr(7, 8'hEC, ir);
      chk(ir, "R11 identify irq", ir, 1);
      for (int i = 0; i < IDB; i++) begin
         logic [7:0] e;
         case (i)
            0: e = 8'h40;
            2: e = 8'(CY);
            3: e = 8'(CY >> 8);
            6: e = 8'(HD);
            7: e = 8'(HD >> 8);
            12: e = 8'(SP);
            default: e = 8'h00;
         endcase
         rd(0, d, ir);
         chk(d == e, "R11 identify byte", d, e);
         chk(ir == (i % SB == 0), "R11 identify sector irq", ir, (i % SB == 0));
      end
      rd(0, d, ir);
      chk(d == 8'h00 && !ir, "R11 identify end", d, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule